// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and presents them to a processor on two lines. `irq` is the normal-priority request and `fiq` is the fast request. Every source has its own enable bit and its own steering bit. The steering bit decides which of the two lines the source drives.

Software reaches the block through a plain 32-bit register port. Writes take effect on the clock edge and reads are combinational. Through this port software reads:
- the raw sampled source levels;
- a masked status word for each line;
- a ready-made readout of the most urgent source on each line.

The most urgent source is the lowest-numbered active bit, so software can go straight to the right handler without scanning the status word. The source inputs are registered once inside the block, so every view and both output lines follow the inputs one clock later. There is no edge capture: a source counts as pending only while its input is high.

Top module: `intc_dual_out`

## Requirements
- R1: The word at offset 0x00 reads the source inputs as sampled at the previous rising clock edge, with no regard to enable or steering.
- R2: The word at offset 0x04 is the per-source enable and the word at offset 0x08 is the per-source steering. Both can be written and read back. Steering bit value 0 sends the source to `irq` and value 1 sends it to `fiq`.
- R3: The word at offset 0x0C reads pending AND enable AND NOT steering. The word at offset 0x10 reads pending AND enable AND steering.
- R4: `irq` is high exactly when the 0x0C view is non-zero, and `fiq` is high exactly when the 0x10 view is non-zero. A change on a source input reaches the line after the next rising edge.
- R5: A source whose enable bit is 0 still shows in the 0x00 word, but it appears in neither status view and drives neither line.
- R6: The words at offsets 0x18 (for `irq`) and 0x1C (for `fiq`) report the lowest-numbered set bit of that line's status view:
  - bit 31 is a valid flag;
  - bits 4:0 hold the source number;
  - all other bits read 0.
  If the view is empty, the whole word reads 0.
- R7: Writes to offsets 0x00, 0x0C, 0x10, 0x14, 0x18 and 0x1C change nothing.
- R8: The order among sources is fixed, with source 0 the most urgent. The word at offset 0x14 always reads 0.
- R9: Synchronous active-high reset clears the sampled sources, the enable word and the steering word, so both lines are low after reset.
- R10: Address bits 1:0 are ignored. Any word address above 0x1C reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| src | input | 32 | Level-sensitive interrupt sources |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The bench puts sources at both ends of the vector, bit 0 and bit 31, on each line and checks the readout. An encoder that scans in the wrong direction would report the highest source, and an off-by-one would report a neighbour or miss bit 31. Random mixes of enable, steering and source words are checked against a model computed in the bench; a steering bit that is inverted or ignored puts a source on both lines or on the wrong one. Writes of all ones to every read-only word and to an unmapped word must leave enable and steering unchanged, and an empty view must read as all zeros rather than as source 0 with the flag set.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int INTC_DW   = 32;
    localparam int INTC_NSRC = 32;
    localparam int INTC_AW   = 6;
    localparam int INTC_NOUT = 2;

    // register word index = byte offset / 4; the order is the software map
    typedef enum logic [2:0] {
        REG_RAW    = 3'd0,
        REG_ENA    = 3'd1,
        REG_STEER  = 3'd2,
        REG_NRMST  = 3'd3,
        REG_FSTST  = 3'd4,
        REG_ORDER  = 3'd5,
        REG_NRMTOP = 3'd6,
        REG_FSTTOP = 3'd7
    } reg_e;

    typedef enum logic {
        OUT_NRM = 1'b0,
        OUT_FST = 1'b1
    } out_e;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NSRC = INTC_NSRC,
    parameter int DW   = INTC_DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            in_map,
    input  reg_e            word,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] src,
    output logic [NSRC-1:0] pend_q,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] steer_q
);
    logic wr_ok;
    assign wr_ok = wr_en && in_map;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            en_q    <= '0;
            steer_q <= '0;
        end else begin
            pend_q <= src;
            if (wr_ok && word == REG_ENA)
                en_q <= wdata[NSRC-1:0];
            if (wr_ok && word == REG_STEER)
                steer_q <= wdata[NSRC-1:0];
        end
    end
endmodule

// File: rtl/intc_route.sv
module intc_route
    import intc_pkg::*;
#(
    parameter int NSRC = INTC_NSRC,
    parameter int NOUT = INTC_NOUT
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] steer,
    output logic [NSRC-1:0] view [NOUT],
    output logic [NOUT-1:0] line
);
    logic [NSRC-1:0] live;
    assign live = pend & en;

    for (genvar k = 0; k < NOUT; k++) begin : g_out
        if (k == int'(OUT_FST)) begin : g_fast
            assign view[k] = live & steer;
        end else begin : g_norm
            assign view[k] = live & ~steer;
        end
        assign line[k] = |view[k];
    end
endmodule

// File: rtl/intc_pick.sv
module intc_pick
    import intc_pkg::*;
#(
    parameter int NSRC = INTC_NSRC,
    parameter int DW   = INTC_DW
) (
    input  logic [NSRC-1:0] vec,
    output logic [DW-1:0]   code
);
    localparam int IW = $clog2(NSRC);

    logic          hit;
    logic [IW-1:0] idx;

    // scan from the top so the lowest set bit is the last one written
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = i[IW-1:0];
            end
        end
    end

    assign code = {hit, (DW-1)'(idx)};
endmodule

// File: rtl/intc_dual_out.sv
module intc_dual_out
    import intc_pkg::*;
#(
    parameter int NSRC = INTC_NSRC,
    parameter int DW   = INTC_DW,
    parameter int AW   = INTC_AW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NSRC-1:0] src,
    output logic            irq,
    output logic            fiq
);
    localparam int NOUT = INTC_NOUT;

    logic            in_map;
    reg_e            word;
    logic [1:0]      unused_lsb;
    logic [NSRC-1:0] pend_q, en_q, steer_q;
    logic [NSRC-1:0] view [NOUT];
    logic [NOUT-1:0] line;
    logic [DW-1:0]   top_code [NOUT];

    assign unused_lsb = addr[1:0];
    assign in_map     = (addr[AW-1:5] == '0);
    assign word       = reg_e'(addr[4:2]);

    intc_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .in_map(in_map), .word(word),
        .wdata(wdata), .src(src),
        .pend_q(pend_q), .en_q(en_q), .steer_q(steer_q)
    );

    intc_route #(.NSRC(NSRC), .NOUT(NOUT)) u_route (
        .pend(pend_q), .en(en_q), .steer(steer_q), .view(view), .line(line)
    );

    for (genvar k = 0; k < NOUT; k++) begin : g_pick
        intc_pick #(.NSRC(NSRC), .DW(DW)) u_pick (
            .vec(view[k]), .code(top_code[k])
        );
    end

    assign irq = line[OUT_NRM];
    assign fiq = line[OUT_FST];

    always_comb begin
        rdata = '0;
        if (in_map) begin
            unique case (word)
                REG_RAW:    rdata = DW'(pend_q);
                REG_ENA:    rdata = DW'(en_q);
                REG_STEER:  rdata = DW'(steer_q);
                REG_NRMST:  rdata = DW'(view[OUT_NRM]);
                REG_FSTST:  rdata = DW'(view[OUT_FST]);
                REG_ORDER:  rdata = '0;
                REG_NRMTOP: rdata = top_code[OUT_NRM];
                REG_FSTTOP: rdata = top_code[OUT_FST];
            endcase
        end
    end
endmodule

// File: rtl/intc_dual_out_chk.sv
module intc_dual_out_chk
    import intc_pkg::*;
#(
    parameter int NSRC = INTC_NSRC,
    parameter int DW   = INTC_DW,
    parameter int AW   = INTC_AW
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [AW-1:0]   addr,
    input logic [DW-1:0]   wdata,
    input logic            irq,
    input logic            fiq,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] steer_q,
    input logic [NSRC-1:0] nrm_view,
    input logic [NSRC-1:0] fst_view,
    input logic [DW-1:0]   nrm_code
);
    localparam int IW = $clog2(NSRC);

    logic [IW-1:0]   nrm_idx;
    logic [NSRC-1:0] below_mask;
    logic            wr_ro;

    assign nrm_idx    = nrm_code[IW-1:0];
    assign below_mask = (NSRC'(1) << nrm_idx) - NSRC'(1);
    assign wr_ro = wr_en && addr[AW-1:5] == '0 &&
                   !(addr[4:2] == 3'd1 || addr[4:2] == 3'd2);

    // R3: a source can never sit in both status views
    p_views_disjoint_r3: assert property (@(posedge clk) disable iff (rst)
        (nrm_view & fst_view) == '0);

    // R5: clearing every enable bit silences both lines on the next cycle
    p_mask_all_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[AW-1:5] == '0 && addr[4:2] == 3'd1 && wdata == '0)
        |=> (!irq && !fiq));

    // R6: valid flag of the normal readout agrees with the irq line
    p_flag_matches_line_r6: assert property (@(posedge clk) disable iff (rst)
        nrm_code[DW-1] == irq);

    // R6: reported source is active and no lower source is active
    p_pick_lowest_r6: assert property (@(posedge clk) disable iff (rst)
        nrm_code[DW-1] |-> (nrm_view[nrm_idx] && (nrm_view & below_mask) == '0));

    // R7: writes to read-only words leave enable and steering alone
    p_ro_write_r7: assert property (@(posedge clk) disable iff (rst)
        wr_ro |=> ($stable(en_q) && $stable(steer_q)));

    // R9: reset clears enable and steering
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (en_q == '0 && steer_q == '0));
endmodule

bind intc_dual_out intc_dual_out_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq(irq), .fiq(fiq), .en_q(en_q), .steer_q(steer_q),
    .nrm_view(view[0]), .fst_view(view[1]), .nrm_code(top_code[0])
);

// File: tb/sim_intc_dual_out.sv
`timescale 1ns/1ps
module sim_intc_dual_out;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] src = '0;
    logic        irq, fiq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    intc_dual_out u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src(src), .irq(irq), .fiq(fiq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reference: lowest set bit, flag in bit 31
    function automatic logic [31:0] ref_top(input logic [31:0] v);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 32; i++)
            if (v[i] && !r[31]) r = 32'h8000_0000 | 32'(i);
        return r;
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic drive_src(input logic [31:0] v);
        src = v;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst = 1'b1; src = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        rd(6'h00, d); chk("R9 raw after reset", d, 32'h0);
        rd(6'h04, d); chk("R9 enable after reset", d, 32'h0);
        rd(6'h08, d); chk("R9 steer after reset", d, 32'h0);
        chk("R9 lines after reset", {30'h0, irq, fiq}, 32'h0);
        drive_src(32'h0);
    endtask

    task automatic t_regs_rw();
        logic [31:0] d;
        wr(6'h04, 32'hA5A5_0F0F); rd(6'h04, d); chk("R2 enable readback", d, 32'hA5A5_0F0F);
        wr(6'h08, 32'h1234_8765); rd(6'h08, d); chk("R2 steer readback", d, 32'h1234_8765);
        wr(6'h05, 32'h0000_00FF); rd(6'h07, d); chk("R10 low addr bits ignored", d, 32'h0000_00FF);
    endtask

    task automatic t_raw_and_mask();
        logic [31:0] d;
        wr(6'h04, 32'h0); wr(6'h08, 32'h0);
        src = 32'h8000_0101;
        rd(6'h00, d); chk("R1 raw not yet sampled", d, 32'h0);
        @(posedge clk); #1;
        rd(6'h00, d); chk("R1 raw sampled", d, 32'h8000_0101);
        rd(6'h0C, d); chk("R5 masked normal view", d, 32'h0);
        rd(6'h10, d); chk("R5 masked fast view", d, 32'h0);
        chk("R5 masked lines", {30'h0, irq, fiq}, 32'h0);
        wr(6'h04, 32'h0000_0100);
        chk("R4 irq with one enabled", {31'h0, irq}, 32'h1);
        chk("R4 fiq stays low", {31'h0, fiq}, 32'h0);
        drive_src(32'h0);
        chk("R4 irq drops with source", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h08, 32'h8000_0000);
        drive_src(32'h8000_0001);
        rd(6'h18, d); chk("R6 normal top is source 0", d, 32'h8000_0000);
        rd(6'h1C, d); chk("R6 fast top is source 31", d, 32'h8000_001F);
        wr(6'h08, 32'h0000_0001);
        rd(6'h18, d); chk("R6 normal top is source 31", d, 32'h8000_001F);
        rd(6'h1C, d); chk("R6 fast top is source 0", d, 32'h8000_0000);
        drive_src(32'h0);
        rd(6'h18, d); chk("R6 empty normal top", d, 32'h0);
        rd(6'h1C, d); chk("R6 empty fast top", d, 32'h0);
        drive_src(32'h0000_6C00);
        wr(6'h08, 32'h0);
        rd(6'h18, d); chk("R6 lowest of several", d, 32'h8000_000A);
        drive_src(32'h0);
    endtask

    task automatic t_random();
        logic [31:0] d, e, s, p, nv, fv;
        for (int n = 0; n < 60; n++) begin
            e = $urandom; s = $urandom; p = $urandom;
            if (n % 4 == 0) p = p & (p - 1) & 32'h0F0F_F0F0;
            wr(6'h04, e); wr(6'h08, s); drive_src(p);
            nv = p & e & ~s; fv = p & e & s;
            rd(6'h0C, d); chk("R3 normal view", d, nv);
            rd(6'h10, d); chk("R3 fast view", d, fv);
            rd(6'h18, d); chk("R6 normal top", d, ref_top(nv));
            rd(6'h1C, d); chk("R6 fast top", d, ref_top(fv));
            chk("R4 irq line", {31'h0, irq}, {31'h0, nv != 0});
            chk("R4 fiq line", {31'h0, fiq}, {31'h0, fv != 0});
        end
        drive_src(32'h0);
    endtask

    task automatic t_read_only();
        logic [31:0] d;
        wr(6'h04, 32'h00FF_00FF); wr(6'h08, 32'h0F0F_0F0F);
        drive_src(32'h0000_0003);
        wr(6'h00, 32'hFFFF_FFFF); wr(6'h0C, 32'hFFFF_FFFF); wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h14, 32'hFFFF_FFFF); wr(6'h18, 32'hFFFF_FFFF); wr(6'h1C, 32'hFFFF_FFFF);
        wr(6'h24, 32'hFFFF_FFFF); wr(6'h3C, 32'hFFFF_FFFF);
        rd(6'h04, d); chk("R7 enable untouched", d, 32'h00FF_00FF);
        rd(6'h08, d); chk("R7 steer untouched", d, 32'h0F0F_0F0F);
        rd(6'h00, d); chk("R7 raw untouched", d, 32'h0000_0003);
        rd(6'h0C, d); chk("R7 normal view untouched", d, 32'h0);
        rd(6'h10, d); chk("R7 fast view untouched", d, 32'h0000_0003);
        rd(6'h14, d); chk("R8 order word reads zero", d, 32'h0);
        rd(6'h20, d); chk("R10 unmapped reads zero", d, 32'h0);
        rd(6'h3C, d); chk("R10 top unmapped reads zero", d, 32'h0);
        drive_src(32'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regs_rw();
        t_raw_and_mask();
        t_edges();
        t_random();
        t_read_only();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule